// File: doc/BRIEF.md
# Storage Cycle Timing Ring

This block sequences one memory storage cycle of a 16-bit minicomputer. It produces eight one-hot timing lines, T0 to T7. A fast system clock runs it. A free-running divider splits that clock into phase boundaries, and a small state machine moves one phase at each boundary. With the default parameters a phase is 14 system clocks long, which is 280 ns on a 20 ns clock. An unstretched cycle is therefore 112 clocks, about 2.2 µs.

Three inputs steer the ring. `run` starts it and keeps it cycling. `hold` lets a variable-length add or subtract keep the ring parked in T7 for whole extra phases. `slow_mode` models a reduced-performance machine: it inserts `IDLE_PHASES` dead phases after T7, and no T line is high during them. A one-clock `cycle_start` pulse marks entry to T0. A one-clock `cycle_end` pulse marks the final clock of the last T7.

The state machine has four states:
- `RING_STOPPED`: all lines are low.
- `RING_ACTIVE`: T0..T6, with a phase index.
- `RING_LAST`: T7.
- `RING_DEAD`: slow-mode idle, with an idle counter.

All transitions are taken only on a phase boundary:
- STOPPED→ACTIVE when `run` is high.
- ACTIVE→ACTIVE, with the index incremented, for T0..T5.
- ACTIVE→LAST from T6.
- LAST→LAST when `hold` is high.
- LAST→DEAD when `hold` is low and `slow_mode` is high.
- LAST→ACTIVE(T0) when `hold` and `slow_mode` are low and `run` is high.
- LAST→STOPPED when `hold`, `slow_mode` and `run` are all low.
- DEAD→DEAD until the last idle phase.
- DEAD→ACTIVE(T0) after the last idle phase when `run` is high.
- DEAD→STOPPED after the last idle phase when `run` is low.

Top module: `tphase_ring`

## Requirements
- R1: A synchronous reset (`rst` high) stops the ring. All T lines, `cycle_start` and `cycle_end` are low on the clock after the reset edge, and they stay low while `run` is low.
- R2: At most one T line is high at any time. None is high during slow-mode idle phases or while stopped.
- R3: Once started, the ring goes T0, T1, ..., T7 in order (bit i of `t_phase` is Ti). Each of T0..T6 lasts exactly CLKS_PER_PHASE (14) clocks, and T7 lasts a whole multiple of 14 clocks.
- R4: With `slow_mode` low, `hold` low and `run` high, T0 follows T7 with no gap. Consecutive `cycle_start` pulses are 112 clocks apart.
- R5: `hold` is sampled on the last clock of each T7 phase. Each boundary that sees it high adds one more 14-clock T7 phase.
- R6: `hold` high during T0..T6 has no effect. If it is low at the end of T7, the cycle is still 112 clocks.
- R7: With `slow_mode` high at the end of T7, IDLE_PHASES (4) phases of 14 clocks with every T line low follow before the next T0. The cycle is then 168 clocks.
- R8: `cycle_start` is high for exactly one clock, the first clock of T0.
- R9: `cycle_end` is high for exactly one clock per cycle, the last clock of the final T7 (the one at whose end `hold` is low).
- R10: If `run` drops mid-cycle, the cycle still finishes through T7 (including held T7 phases and slow-mode idle) before the ring stops, and no new T0 begins.
- R11: From stopped, raising `run` starts T0 at the next phase boundary, within 1 to 14 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Keep cycling; sampled at cycle boundaries |
| hold | input | 1 | Stretch T7 by one phase when high at T7's end |
| slow_mode | input | 1 | Insert idle phases after T7 |
| t_phase | output | NUM_PHASES (8) | One-hot timing lines, bit i = Ti |
| cycle_start | output | 1 | One-clock pulse on the first clock of T0 |
| cycle_end | output | 1 | One-clock pulse on the last clock of the final T7 |

## Verification
The hardest states to reach from the ports are a stretched T7 of a known length and a run drop that lands inside a held T7 or inside slow-mode idle. The bench aligns its stimulus to the observed phase lines. It raises `hold` on the first sampled clock of T7 and holds it for an exact multiple of 14 clocks, so a chosen number of T7 boundaries see it. It drops `run` only after it has seen T3 or the first idle clock. A table of mode and hold-count vectors measures the spacing of `cycle_start` pulses and the idle clocks between them.

// File: rtl/tphase_pkg.sv
`timescale 1ns/1ps
package tphase_pkg;
    typedef enum logic [1:0] {
        RING_STOPPED = 2'd0,
        RING_ACTIVE  = 2'd1,
        RING_LAST    = 2'd2,
        RING_DEAD    = 2'd3
    } ring_state_e;
endpackage

// File: rtl/tphase_tick.sv
`timescale 1ns/1ps
module tphase_tick #(
    parameter int DIV = 14
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] TOP = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst)               cnt_q <= '0;
                else if (cnt_q == TOP) cnt_q <= '0;
                else                   cnt_q <= cnt_q + CW'(1);
            end

            assign tick = (cnt_q == TOP);

            // R3: boundaries are never adjacent
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tphase_seq.sv
`timescale 1ns/1ps
module tphase_seq
    import tphase_pkg::*;
#(
    parameter int NUM_PHASES  = 8,
    parameter int IDLE_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  run,
    input  logic                  hold,
    input  logic                  slow,
    output logic [NUM_PHASES-1:0] t_phase,
    output logic                  cycle_start,
    output logic                  cycle_end
);
    localparam int PW = $clog2(NUM_PHASES);
    localparam int IW = (IDLE_PHASES > 1) ? $clog2(IDLE_PHASES) : 1;
    localparam bit HAS_IDLE = (IDLE_PHASES > 0);
    localparam logic [IW-1:0] IDLE_LAST = IW'(HAS_IDLE ? IDLE_PHASES - 1 : 0);
    localparam logic [PW-1:0] PRE_LAST  = PW'(NUM_PHASES - 2);
    localparam int LAST_BIT = NUM_PHASES - 1;

    ring_state_e     state_q, state_d;
    logic [PW-1:0]   idx_q, idx_d;
    logic [IW-1:0]   icnt_q, icnt_d;
    logic            start_q, enter_t0;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        icnt_d   = icnt_q;
        enter_t0 = 1'b0;
        if (tick) begin
            unique case (state_q)
                RING_STOPPED: begin
                    if (run) begin
                        state_d  = RING_ACTIVE;
                        idx_d    = '0;
                        enter_t0 = 1'b1;
                    end
                end
                RING_ACTIVE: begin
                    if (idx_q == PRE_LAST) state_d = RING_LAST;
                    else                   idx_d   = idx_q + PW'(1);
                end
                RING_LAST: begin
                    if (hold) begin
                        state_d = RING_LAST;
                    end else if (slow && HAS_IDLE) begin
                        state_d = RING_DEAD;
                        icnt_d  = '0;
                    end else if (run) begin
                        state_d  = RING_ACTIVE;
                        idx_d    = '0;
                        enter_t0 = 1'b1;
                    end else begin
                        state_d = RING_STOPPED;
                    end
                end
                RING_DEAD: begin
                    if (icnt_q == IDLE_LAST) begin
                        if (run) begin
                            state_d  = RING_ACTIVE;
                            idx_d    = '0;
                            enter_t0 = 1'b1;
                        end else begin
                            state_d = RING_STOPPED;
                        end
                    end else begin
                        icnt_d = icnt_q + IW'(1);
                    end
                end
                default: state_d = RING_STOPPED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RING_STOPPED;
            idx_q   <= '0;
            icnt_q  <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            icnt_q  <= icnt_d;
            start_q <= enter_t0;
        end
    end

    // outputs
    always_comb begin
        t_phase   = '0;
        cycle_end = 1'b0;
        unique case (state_q)
            RING_ACTIVE: t_phase[idx_q] = 1'b1;
            RING_LAST: begin
                t_phase[LAST_BIT] = 1'b1;
                cycle_end         = tick & ~hold;
            end
            default: ;
        endcase
    end

    assign cycle_start = start_q;

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(t_phase));
    a_r3_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(t_phase));
    a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
        (t_phase[LAST_BIT] && tick && !hold && !slow && run) |=> t_phase[0]);
    a_r5_hold_keeps_last: assert property (@(posedge clk) disable iff (rst)
        (t_phase[LAST_BIT] && tick && hold) |=> t_phase[LAST_BIT]);
    a_r7_dead_after_last: assert property (@(posedge clk) disable iff (rst)
        (t_phase[LAST_BIT] && tick && !hold && slow && HAS_IDLE) |=> (t_phase == '0));
    a_r8_start_in_t0: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> t_phase[0]);
    a_r9_end_in_last: assert property (@(posedge clk) disable iff (rst)
        cycle_end |-> (t_phase[LAST_BIT] && tick));
    a_r10_stop_after_last: assert property (@(posedge clk) disable iff (rst)
        (t_phase[LAST_BIT] && tick && !hold && !slow && !run) |=> ((t_phase == '0) && !cycle_start));
endmodule

// File: rtl/tphase_ring.sv
`timescale 1ns/1ps
module tphase_ring #(
    parameter int CLKS_PER_PHASE = 14,
    parameter int NUM_PHASES     = 8,
    parameter int IDLE_PHASES    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  hold,
    input  logic                  slow_mode,
    output logic [NUM_PHASES-1:0] t_phase,
    output logic                  cycle_start,
    output logic                  cycle_end
);
    logic phase_tick;

    tphase_tick #(
        .DIV (CLKS_PER_PHASE)
    ) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (phase_tick)
    );

    tphase_seq #(
        .NUM_PHASES  (NUM_PHASES),
        .IDLE_PHASES (IDLE_PHASES)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .tick        (phase_tick),
        .run         (run),
        .hold        (hold),
        .slow        (slow_mode),
        .t_phase     (t_phase),
        .cycle_start (cycle_start),
        .cycle_end   (cycle_end)
    );
endmodule

// File: tb/tphase_ring_tb_top.sv
`timescale 1ns/1ps
module tphase_ring_tb_top;
    localparam int PH = 14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       hold = 1'b0;
    logic       slow_mode = 1'b0;
    logic [7:0] t_phase;
    logic       cycle_start, cycle_end;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // monitor state
    int prev_ph = -1;
    int run_len = 0;
    bit st_prev = 1'b0;
    bit en_prev = 1'b0;
    int err_r2 = 0, err_r3 = 0, err_r8 = 0, err_r9 = 0;

    // columns: slow, hold phases, expected period, expected idle clocks
    localparam int VEC [0:5][0:3] = '{
        '{0, 0, 112, 0},
        '{0, 1, 126, 0},
        '{0, 3, 154, 0},
        '{1, 0, 168, 56},
        '{1, 2, 196, 56},
        '{0, 0, 112, 0}
    };

    always #5 clk = ~clk;

    tphase_ring dut_i (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .hold        (hold),
        .slow_mode   (slow_mode),
        .t_phase     (t_phase),
        .cycle_start (cycle_start),
        .cycle_end   (cycle_end)
    );

    function automatic int ph_index(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // continuous monitor for R2, R3, R8, R9
    always @(negedge clk) begin
        if (rst) begin
            prev_ph = -1;
            run_len = 0;
            st_prev = 1'b0;
            en_prev = 1'b0;
        end else begin
            int cur;
            cur = ph_index(t_phase);
            if ($countones(t_phase) > 1) err_r2++;
            if (cur == prev_ph) begin
                run_len++;
            end else begin
                if (prev_ph >= 0 && prev_ph < 7 && run_len != PH) err_r3++;
                if (prev_ph == 7 && (run_len % PH) != 0) err_r3++;
                if (cur >= 0 && !((prev_ph < 0 && cur == 0) || (prev_ph >= 0 && cur == prev_ph + 1)
                                  || (prev_ph == 7 && cur == 0))) err_r3++;
                if (cur < 0 && prev_ph >= 0 && prev_ph != 7) err_r3++;
                run_len = 1;
            end
            if (cycle_start && (cur != 0 || st_prev)) err_r8++;
            if (cycle_end && (cur != 7 || en_prev)) err_r9++;
            st_prev = cycle_start;
            en_prev = cycle_end;
            prev_ph = cur;
        end
    end

    task automatic wait_start(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cycle_start && waited < 2000);
    endtask

    task automatic wait_bit(input int b);
        int n = 0;
        while (!t_phase[b] && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int w;
        int bad;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(t_phase == 8'h00 && !cycle_start && !cycle_end, "R1 in reset", int'(t_phase), 0);
        rst = 1'b0;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (t_phase != 8'h00 || cycle_start || cycle_end) bad++;
        end
        check(bad == 0, "R1 stays stopped with run low", bad, 0);

        // R11: start latency
        run = 1'b1;
        wait_start(w);
        check(w >= 1 && w <= PH, "R11 start latency", w, PH);

        // table of mode / hold vectors (R4 R5 R7 R9)
        for (int i = 0; i < 6; i++) begin
            int per, idle, ends, hl;
            bit seen7;
            string tg;
            tg = (VEC[i][0] != 0) ? "R7" : ((VEC[i][1] != 0) ? "R5" : "R4");
            if (i > 0) wait_start(w);
            slow_mode = (VEC[i][0] != 0);
            per = 0; idle = 0; ends = 0; hl = 0; seen7 = 1'b0;
            do begin
                @(negedge clk);
                per++;
                if (hl > 0) begin
                    hl--;
                    if (hl == 0) hold = 1'b0;
                end
                if (t_phase[7] && !seen7) begin
                    seen7 = 1'b1;
                    if (VEC[i][1] > 0) begin
                        hold = 1'b1;
                        hl = VEC[i][1] * PH;
                    end
                end
                if (t_phase == 8'h00) idle++;
                if (cycle_end) ends++;
            end while (!cycle_start && per < 2000);
            hold = 1'b0;
            check(per == VEC[i][2], {tg, " cycle period"}, per, VEC[i][2]);
            check(idle == VEC[i][3], "R7 idle clocks", idle, VEC[i][3]);
            check(ends == 1, "R9 one end pulse per cycle", ends, 1);
        end
        slow_mode = 1'b0;

        // R6: hold during T0..T6 ignored
        wait_start(w);
        hold = 1'b1;
        begin
            int per = 0;
            do begin
                @(negedge clk);
                per++;
                if (t_phase[7]) hold = 1'b0;
            end while (!cycle_start && per < 2000);
            check(per == 112, "R6 early hold ignored", per, 112);
        end

        // R10: run drop at T3, one held T7, then stop
        wait_bit(3);
        run = 1'b0;
        wait_bit(7);
        hold = 1'b1;
        begin
            int t7 = 0, ends = 0, starts = 0, late = 0;
            bit gone = 1'b0;
            for (int k = 0; k < 300; k++) begin
                if (t_phase[7]) t7++;
                if (cycle_end) ends++;
                if (cycle_start) starts++;
                if (gone && t_phase != 8'h00) late++;
                if (t_phase == 8'h00) gone = 1'b1;
                @(negedge clk);
                if (k == PH - 1) hold = 1'b0;
            end
            check(t7 == 28, "R10 held T7 completes", t7, 28);
            check(ends == 1, "R10 end pulse before stop", ends, 1);
            check(starts == 0 && late == 0, "R10 no new cycle", starts + late, 0);
        end

        // R11 restart, then slow-mode stop during idle (R7 R10)
        run = 1'b1;
        slow_mode = 1'b1;
        wait_start(w);
        check(w >= 1 && w <= PH, "R11 restart latency", w, PH);
        wait_bit(7);
        while (t_phase != 8'h00) @(negedge clk);
        run = 1'b0;
        begin
            int starts = 0, lit = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (cycle_start) starts++;
                if (t_phase != 8'h00) lit++;
            end
            check(starts == 0 && lit == 0, "R10 stop from slow idle", starts + lit, 0);
        end

        // R1: reset mid-cycle
        slow_mode = 1'b0;
        run = 1'b1;
        wait_start(w);
        wait_bit(4);
        rst = 1'b1;
        @(negedge clk);
        check(t_phase == 8'h00 && !cycle_start && !cycle_end, "R1 mid-cycle reset", int'(t_phase), 0);
        rst = 1'b0;
        wait_start(w);
        check(w >= 1 && w <= PH, "R11 start after reset", w, PH);
        repeat (120) @(negedge clk);

        check(err_r2 == 0, "R2 one-hot monitor", err_r2, 0);
        check(err_r3 == 0, "R3 order and length monitor", err_r3, 0);
        check(err_r8 == 0, "R8 start pulse monitor", err_r8, 0);
        check(err_r9 == 0, "R9 end pulse monitor", err_r9, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule